// File: doc/BRIEF.md
# Burst SRAM Cycle Controller

This block is the clocked command decoder in front of a pipelined burst static RAM. On every rising edge it samples three chip enables, two address strobes, an advance input, the write-request controls and a sleep input. From these it classifies the next cycle as unselected, a fresh read, a fresh write, a burst continuation or a burst suspension. It then drives the load and step controls of a two-bit burst sequencer and the per-byte write strobes of the storage array. The data-bus drive enable is formed combinationally from the output-enable pin.

The first strobe (the host-side strobe) can only open reads, and only the first chip enable gates it. The second strobe (the controller-side strobe) opens either a read or a write, depending on the write request. Once a burst is open, cycles with both strobes inactive either step the address or hold it. The step order is linear (wrapping increment) or interleaved (XOR with a count), selected by a mode pin. A small inferred word array sits behind the decoder so that whole bursts can be exercised end to end. Read data appear one clock after the address is registered.

Top module: `burst_sram_ctrl`

## Requirements
- R1: A write is requested when `gwr_n_i` is 0, or when `bwe_n_i` is 0 and at least one bit of `ben_n_i` is 0. For a write cycle `wr_stb_o` is 4'hF when `gwr_n_i` is 0, and otherwise the bitwise inverse of `ben_n_i` (bit b enables byte lane b, bits 8b+7..8b). With no write request the cycle is a read and `wr_stb_o` is 0.
- R2: The chip is selected only for `cs1_n_i`=0, `cs2_i`=1 and `cs3_n_i`=0. Any other combination sampled with an active strobe gives an unselected cycle: no write strobe, no address change, no bus drive, and the open burst is closed so that later continue cycles do nothing.
- R3: With `pstb_n_i`=0, `cs1_n_i`=0 and the chip selected, a read begins at `addr_i`, whatever the write-request inputs are.
- R4: With `cs1_n_i`=1, `pstb_n_i` is ignored. Then `cstb_n_i`=0 gives an unselected cycle, and `cstb_n_i`=1 gives a continue or suspend cycle.
- R5: With `cstb_n_i`=0 and the host strobe not in effect, a selected chip begins at `addr_i` a write if a write is requested and a read otherwise.
- R6: With both strobes inactive and a burst open, `adv_n_i`=0 steps the burst address and `adv_n_i`=1 holds it. The cycle is a write or a read according to R1. With no burst open (after reset or an unselected cycle), such cycles do nothing.
- R7: With `lin_burst_i`=1 at burst start, the two low address bits of the n-th burst cycle are (start + n) mod 4. The upper bits do not change.
- R8: With `lin_burst_i`=0 at burst start, the two low address bits of the n-th burst cycle are start XOR (n mod 4).
- R9: `burst_addr_o` and `wr_stb_o` show the cycle decoded at the latest edge. A read's data appear on `rdata_o` after the following edge. A write stores the byte lanes of its strobe at its address, so a later read returns the merged word.
- R10: `dq_oe_o` is 1 only when the previous registered cycle was a read, the current cycle is not a write, the device is not asleep and `oe_n_i` is 0. It follows `oe_n_i` without waiting for a clock edge.
- R11: An edge that samples `sleep_i`=1 ignores every other input. `sleep_o` rises after two consecutive high samples. The two edges after the last high sample still ignore all inputs.
- R12: After reset, `burst_addr_o`, `wr_stb_o`, `rdata_o`, `dq_oe_o` and `sleep_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sleep_i | input | 1 | Sleep request, active high |
| cs1_n_i | input | 1 | Chip enable 1, active low, also gates the host strobe |
| cs2_i | input | 1 | Chip enable 2, active high |
| cs3_n_i | input | 1 | Chip enable 3, active low |
| pstb_n_i | input | 1 | Host-side address strobe, active low, read only |
| cstb_n_i | input | 1 | Controller-side address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| gwr_n_i | input | 1 | Global write, active low |
| bwe_n_i | input | 1 | Byte-write qualifier, active low |
| ben_n_i | input | NB | Per-byte write enables, active low |
| lin_burst_i | input | 1 | Burst order: 1 linear, 0 interleaved |
| addr_i | input | AW | External word address |
| wdata_i | input | DW | Write data |
| oe_n_i | input | 1 | Output enable, active low, not clocked |
| rdata_o | output | DW | Read data |
| dq_oe_o | output | 1 | Data-bus drive enable |
| wr_stb_o | output | NB | Registered per-byte write strobes |
| burst_addr_o | output | AW | Address of the current cycle |
| sleep_o | output | 1 | Array in standby |

## Verification
The bench covers the precedence corners of the decoder. The host strobe is driven with write controls active, which a wrong design would turn into a write. The host strobe is also driven with chip enable 1 high, where a design that does not ignore it would reload the address. Partial chip selects test whether an unselected cycle still strobes the array or leaves the burst open. Bursts are run from a start offset of 1 in both orders, because that offset gives different sequences for the two modes, and both orders are run through their wrap. Byte-masked overwrites show whether lane decoding is mis-ordered. The sleep sequence tests whether entry and recovery are off by one edge, and the read-then-write sequence shows whether the bus is left driven into a write cycle.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

  typedef enum logic [1:0] {
    CY_IDLE  = 2'd0,
    CY_READ  = 2'd1,
    CY_WRITE = 2'd2
  } cyc_e;

endpackage

// File: rtl/sbc_decode.sv
module sbc_decode
  import sbc_pkg::*;
#(
  parameter int NB = 4
) (
  input  logic          accept_i,
  input  logic          active_i,
  input  logic          cs1_n_i,
  input  logic          cs2_i,
  input  logic          cs3_n_i,
  input  logic          pstb_n_i,
  input  logic          cstb_n_i,
  input  logic          adv_n_i,
  input  logic          gwr_n_i,
  input  logic          bwe_n_i,
  input  logic [NB-1:0] ben_n_i,
  output logic          load_o,
  output logic          step_o,
  output logic          open_o,
  output logic          close_o,
  output cyc_e          op_o,
  output logic [NB-1:0] strb_o
);

  logic          sel;
  logic          wreq;
  logic [NB-1:0] lanes;

  always_comb begin
    sel   = !cs1_n_i && cs2_i && !cs3_n_i;
    wreq  = !gwr_n_i || (!bwe_n_i && !(&ben_n_i));
    lanes = !gwr_n_i ? {NB{1'b1}} : (!bwe_n_i ? ~ben_n_i : {NB{1'b0}});

    load_o  = 1'b0;
    step_o  = 1'b0;
    open_o  = 1'b0;
    close_o = 1'b0;
    op_o    = CY_IDLE;

    if (accept_i) begin
      if (!pstb_n_i && !cs1_n_i) begin
        // host strobe: read only, write controls ignored
        if (sel) begin
          load_o = 1'b1;
          open_o = 1'b1;
          op_o   = CY_READ;
        end else begin
          close_o = 1'b1;
        end
      end else if (!cstb_n_i) begin
        if (sel) begin
          load_o = 1'b1;
          open_o = 1'b1;
          op_o   = wreq ? CY_WRITE : CY_READ;
        end else begin
          close_o = 1'b1;
        end
      end else if (active_i) begin
        step_o = !adv_n_i;
        op_o   = wreq ? CY_WRITE : CY_READ;
      end
    end

    strb_o = (op_o == CY_WRITE) ? lanes : {NB{1'b0}};
  end

endmodule

// File: rtl/sbc_burst.sv
module sbc_burst #(
  parameter int AW = 6,
  parameter int BB = 2
) (
  input  logic          clk_i,
  input  logic          rst_n_i,
  input  logic          load_i,
  input  logic          step_i,
  input  logic          lin_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] cur_addr_o
);

  logic [AW-1:0] base_q, base_d;
  logic [BB-1:0] cnt_q, cnt_d;
  logic          lin_q, lin_d;
  logic [BB-1:0] lo;

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    lin_d  = lin_q;
    if (load_i) begin
      base_d = addr_i;
      cnt_d  = '0;
      lin_d  = lin_i;
    end else if (step_i) begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      base_q <= '0;
      cnt_q  <= '0;
      lin_q  <= 1'b1;
    end else if (load_i || step_i) begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
      lin_q  <= lin_d;
    end
  end

  always_comb begin
    lo = lin_q ? (base_q[BB-1:0] + cnt_q) : (base_q[BB-1:0] ^ cnt_q);
    cur_addr_o = {base_q[AW-1:BB], lo};
  end

endmodule

// File: rtl/sbc_array.sv
module sbc_array #(
  parameter int AW = 6,
  parameter int DW = 32,
  parameter int NB = DW / 8
) (
  input  logic          clk_i,
  input  logic          rst_n_i,
  input  logic          rd_en_i,
  input  logic [NB-1:0] wr_stb_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    for (int b = 0; b < NB; b++) begin
      if (wr_stb_i[b]) mem[addr_i][8*b +: 8] <= wdata_i[8*b +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)     rdata_o <= '0;
    else if (rd_en_i) rdata_o <= mem[addr_i];
  end

endmodule

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import sbc_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 32,
  parameter int NB = DW / 8,
  parameter int BB = 2
) (
  input  logic          clk_i,
  input  logic          rst_n_i,
  input  logic          sleep_i,
  input  logic          cs1_n_i,
  input  logic          cs2_i,
  input  logic          cs3_n_i,
  input  logic          pstb_n_i,
  input  logic          cstb_n_i,
  input  logic          adv_n_i,
  input  logic          gwr_n_i,
  input  logic          bwe_n_i,
  input  logic [NB-1:0] ben_n_i,
  input  logic          lin_burst_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          oe_n_i,
  output logic [DW-1:0] rdata_o,
  output logic          dq_oe_o,
  output logic [NB-1:0] wr_stb_o,
  output logic [AW-1:0] burst_addr_o,
  output logic          sleep_o
);

  // reset: asynchronous assert, synchronous release
  logic rst_m_q, rst_n_s;
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rst_m_q <= 1'b0;
      rst_n_s <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_n_s <= rst_m_q;
    end
  end

  logic          zz1_q, zz2_q;
  logic          accept;
  logic          act_q, act_d;
  cyc_e          op_q, op_d;
  logic [NB-1:0] strb_q, strb_d;
  logic [DW-1:0] wdat_q;
  logic          rdv_q;
  logic          load, step, open_b, close_b;

  assign accept = !sleep_i && !zz1_q && !zz2_q;

  sbc_decode #(.NB(NB)) u_dec (
    .accept_i (accept),
    .active_i (act_q),
    .cs1_n_i  (cs1_n_i),
    .cs2_i    (cs2_i),
    .cs3_n_i  (cs3_n_i),
    .pstb_n_i (pstb_n_i),
    .cstb_n_i (cstb_n_i),
    .adv_n_i  (adv_n_i),
    .gwr_n_i  (gwr_n_i),
    .bwe_n_i  (bwe_n_i),
    .ben_n_i  (ben_n_i),
    .load_o   (load),
    .step_o   (step),
    .open_o   (open_b),
    .close_o  (close_b),
    .op_o     (op_d),
    .strb_o   (strb_d)
  );

  sbc_burst #(.AW(AW), .BB(BB)) u_seq (
    .clk_i      (clk_i),
    .rst_n_i    (rst_n_s),
    .load_i     (load),
    .step_i     (step),
    .lin_i      (lin_burst_i),
    .addr_i     (addr_i),
    .cur_addr_o (burst_addr_o)
  );

  always_comb begin
    act_d = act_q;
    if (open_b)       act_d = 1'b1;
    else if (close_b) act_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) begin
      zz1_q  <= 1'b0;
      zz2_q  <= 1'b0;
      act_q  <= 1'b0;
      op_q   <= CY_IDLE;
      strb_q <= '0;
      rdv_q  <= 1'b0;
    end else begin
      zz1_q  <= sleep_i;
      zz2_q  <= zz1_q;
      act_q  <= act_d;
      op_q   <= op_d;
      strb_q <= strb_d;
      rdv_q  <= (op_q == CY_READ);
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s)              wdat_q <= '0;
    else if (op_d == CY_WRITE) wdat_q <= wdata_i;
  end

  sbc_array #(.AW(AW), .DW(DW), .NB(NB)) u_mem (
    .clk_i    (clk_i),
    .rst_n_i  (rst_n_s),
    .rd_en_i  (op_q == CY_READ),
    .wr_stb_i (strb_q),
    .addr_i   (burst_addr_o),
    .wdata_i  (wdat_q),
    .rdata_o  (rdata_o)
  );

  assign sleep_o  = zz1_q && zz2_q;
  assign wr_stb_o = strb_q;
  assign dq_oe_o  = rdv_q && !oe_n_i && (op_q != CY_WRITE) && !sleep_o;

endmodule

// File: rtl/burst_sram_ctrl_chk.sv
module burst_sram_ctrl_chk #(
  parameter int AW = 6,
  parameter int NB = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sleep_i,
  input logic          cs1_n_i,
  input logic          cs2_i,
  input logic          pstb_n_i,
  input logic          cstb_n_i,
  input logic          adv_n_i,
  input logic          gwr_n_i,
  input logic          bwe_n_i,
  input logic          oe_n_i,
  input logic          dq_oe_o,
  input logic [NB-1:0] wr_stb_o,
  input logic [AW-1:0] burst_addr_o
);

  // R1
  strobe_needs_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb_o != '0) |-> $past(!gwr_n_i || !bwe_n_i));

  // R3
  host_strobe_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!pstb_n_i && !cs1_n_i) |-> (wr_stb_o == '0));

  // R2
  unselected_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cs2_i && (!cstb_n_i || (!pstb_n_i && !cs1_n_i))) |-> (wr_stb_o == '0));

  // R6
  suspend_holds_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cstb_n_i && (pstb_n_i || cs1_n_i) && adv_n_i) |-> $stable(burst_addr_o));

  // R10
  bus_drive_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe_o |-> (!oe_n_i && (wr_stb_o == '0)));

  // R11
  sleep_ignores_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sleep_i) |-> (wr_stb_o == '0));

endmodule

bind burst_sram_ctrl burst_sram_ctrl_chk #(.AW(AW), .NB(NB)) u_chk (
  .clk          (clk_i),
  .rst_n        (rst_n_s),
  .sleep_i      (sleep_i),
  .cs1_n_i      (cs1_n_i),
  .cs2_i        (cs2_i),
  .pstb_n_i     (pstb_n_i),
  .cstb_n_i     (cstb_n_i),
  .adv_n_i      (adv_n_i),
  .gwr_n_i      (gwr_n_i),
  .bwe_n_i      (bwe_n_i),
  .oe_n_i       (oe_n_i),
  .dq_oe_o      (dq_oe_o),
  .wr_stb_o     (wr_stb_o),
  .burst_addr_o (burst_addr_o)
);

// File: tb/test_burst_sram_ctrl.sv
module test_burst_sram_ctrl;

  localparam int AW = 6;
  localparam int DW = 32;
  localparam int NB = 4;

  logic          clk = 1'b0;
  logic          rst_n, sleep, cs1_n, cs2, cs3_n, pstb_n, cstb_n, adv_n;
  logic          gwr_n, bwe_n, lin, oe_n;
  logic [NB-1:0] ben_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic          dq_oe, sleep_o;
  logic [NB-1:0] wr_stb;
  logic [AW-1:0] baddr;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  burst_sram_ctrl #(.AW(AW), .DW(DW), .NB(NB)) i_burst_sram_ctrl (
    .clk_i (clk), .rst_n_i (rst_n), .sleep_i (sleep),
    .cs1_n_i (cs1_n), .cs2_i (cs2), .cs3_n_i (cs3_n),
    .pstb_n_i (pstb_n), .cstb_n_i (cstb_n), .adv_n_i (adv_n),
    .gwr_n_i (gwr_n), .bwe_n_i (bwe_n), .ben_n_i (ben_n),
    .lin_burst_i (lin), .addr_i (addr), .wdata_i (wdata), .oe_n_i (oe_n),
    .rdata_o (rdata), .dq_oe_o (dq_oe), .wr_stb_o (wr_stb),
    .burst_addr_o (baddr), .sleep_o (sleep_o)
  );

  // {cs1_n,cs2,cs3_n, pstb_n,cstb_n, adv_n, gwr_n, bwe_n, ben_n[3:0],
  //  addr kind (0 hold,1 step,2 load), expected strobes, expected read}
  localparam logic [18:0] VEC [15] = '{
    {3'b010, 2'b01, 1'b1, 1'b0, 1'b1, 4'hF,    2'd2, 4'h0,    1'b1}, // R3 write ctl ignored
    {3'b010, 2'b00, 1'b1, 1'b1, 1'b1, 4'hF,    2'd2, 4'h0,    1'b1}, // R3 both strobes
    {3'b110, 2'b00, 1'b1, 1'b0, 1'b1, 4'hF,    2'd0, 4'h0,    1'b0}, // R4 unselected
    {3'b110, 2'b01, 1'b0, 1'b1, 1'b1, 4'hF,    2'd1, 4'h0,    1'b1}, // R4 continue
    {3'b000, 2'b01, 1'b1, 1'b1, 1'b1, 4'hF,    2'd0, 4'h0,    1'b0}, // R2 cs2 low
    {3'b011, 2'b01, 1'b1, 1'b1, 1'b1, 4'hF,    2'd0, 4'h0,    1'b0}, // R2 cs3 high
    {3'b010, 2'b10, 1'b1, 1'b0, 1'b1, 4'hF,    2'd2, 4'hF,    1'b0}, // R5 write
    {3'b010, 2'b10, 1'b1, 1'b1, 1'b0, 4'b1010, 2'd2, 4'b0101, 1'b0}, // R1 lanes
    {3'b010, 2'b10, 1'b1, 1'b1, 1'b1, 4'h0,    2'd2, 4'h0,    1'b1}, // R1 no qualifier
    {3'b010, 2'b10, 1'b1, 1'b1, 1'b0, 4'hF,    2'd2, 4'h0,    1'b1}, // R1 no lane
    {3'b010, 2'b11, 1'b0, 1'b1, 1'b1, 4'hF,    2'd1, 4'h0,    1'b1}, // R6 step read
    {3'b010, 2'b11, 1'b1, 1'b0, 1'b1, 4'hF,    2'd0, 4'hF,    1'b0}, // R6 hold write
    {3'b010, 2'b11, 1'b0, 1'b1, 1'b0, 4'b1110, 2'd1, 4'b0001, 1'b0}, // R6 step write
    {3'b000, 2'b10, 1'b1, 1'b1, 1'b1, 4'hF,    2'd0, 4'h0,    1'b0}, // R2 cstb unsel
    {3'b100, 2'b11, 1'b1, 1'b1, 1'b1, 4'hF,    2'd0, 4'h0,    1'b1}  // R6 suspend
  };

  function automatic string vtag(int i);
    case (i)
      0, 1:     return "R3";
      2, 3:     return "R4";
      4, 5, 13: return "R2";
      6:        return "R5";
      7, 8, 9:  return "R1";
      default:  return "R6";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet();
    cs1_n = 0; cs2 = 1; cs3_n = 0; pstb_n = 1; cstb_n = 1; adv_n = 1;
    gwr_n = 1; bwe_n = 1; ben_n = '1; sleep = 0;
  endtask

  task automatic deselect();
    quiet(); cs2 = 0; cstb_n = 0;
  endtask

  task automatic begin_read(logic [AW-1:0] a, logic l);
    quiet(); pstb_n = 0; addr = a; lin = l;
  endtask

  task automatic step(logic wr, logic [DW-1:0] d);
    quiet(); adv_n = 0; gwr_n = !wr; wdata = d;
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [18:0] v;
    logic [AW-1:0] ea;
    rst_n = 0; quiet(); lin = 1; oe_n = 0; addr = '0; wdata = '0;
    repeat (3) tick();
    rst_n = 1;
    repeat (3) tick();

    // R12 reset state
    chk("R12 addr", 32'(baddr), 0);
    chk("R12 strobe", 32'(wr_stb), 0);
    chk("R12 dq_oe", 32'(dq_oe), 0);
    chk("R12 sleep", 32'(sleep_o), 0);
    chk("R12 rdata", rdata, 0);

    // R6 continue with no open burst does nothing
    step(1'b1, 32'h1234_5678); tick();
    chk("R6 idle write", 32'(wr_stb), 0);
    chk("R6 idle addr", 32'(baddr), 0);

    // decode table, each entry after a read opened at address 8
    for (int i = 0; i < 15; i++) begin
      v = VEC[i];
      begin_read(6'd8, 1'b1); tick();
      quiet();
      {cs1_n, cs2, cs3_n, pstb_n, cstb_n, adv_n, gwr_n, bwe_n, ben_n} = v[18:7];
      addr = 6'd20; wdata = 32'hC0DE_0000 + 32'(i);
      tick();
      ea = (v[6:5] == 2'd2) ? 6'd20 : (v[6:5] == 2'd1 ? 6'd9 : 6'd8);
      chk({vtag(i), " addr"}, 32'(baddr), 32'(ea));
      chk({vtag(i), " strobe"}, 32'(wr_stb), 32'(v[4:1]));
      deselect(); tick();
      chk({vtag(i), " read"}, 32'(dq_oe), 32'(v[0]));
    end

    // R7 linear order from offset 1
    begin_read(6'd13, 1'b1); tick();
    chk("R7 n0", 32'(baddr), 13);
    step(1'b0, '0); tick(); chk("R7 n1", 32'(baddr), 14);
    tick(); chk("R7 n2", 32'(baddr), 15);
    tick(); chk("R7 n3", 32'(baddr), 12);
    tick(); chk("R7 wrap", 32'(baddr), 13);

    // R8 interleaved order from offset 1
    begin_read(6'd13, 1'b0); tick();
    chk("R8 n0", 32'(baddr), 13);
    step(1'b0, '0); tick(); chk("R8 n1", 32'(baddr), 12);
    tick(); chk("R8 n2", 32'(baddr), 15);
    tick(); chk("R8 n3", 32'(baddr), 14);
    tick(); chk("R8 wrap", 32'(baddr), 13);

    // R9 write a burst, merge one word, read it back
    quiet(); cstb_n = 0; gwr_n = 0; addr = 6'd32; lin = 1; wdata = 32'h1111_0000;
    tick();
    step(1'b1, 32'h2222_1111); tick();
    step(1'b1, 32'h3333_2222); tick();
    step(1'b1, 32'h4444_3333); tick();
    deselect(); tick();
    quiet(); cstb_n = 0; bwe_n = 0; ben_n = 4'b1100; addr = 6'd33; wdata = 32'hAAAA_5555;
    tick();
    chk("R1 merge strobe", 32'(wr_stb), 32'h3);
    deselect(); tick();
    begin_read(6'd32, 1'b1); tick();
    step(1'b0, '0); tick(); chk("R9 word0", rdata, 32'h1111_0000);
    tick(); chk("R9 word1 merged", rdata, 32'h2222_5555);
    tick(); chk("R9 word2", rdata, 32'h3333_2222);
    deselect(); tick(); chk("R9 word3", rdata, 32'h4444_3333);

    // R10 output enable acts without a clock
    chk("R10 drive", 32'(dq_oe), 1);
    oe_n = 1; #1; chk("R10 oe off", 32'(dq_oe), 0);
    oe_n = 0; #1; chk("R10 oe on", 32'(dq_oe), 1);
    begin_read(6'd8, 1'b1); tick();
    quiet(); cstb_n = 0; gwr_n = 0; addr = 6'd9; wdata = 32'h0;
    tick();
    chk("R10 write mask", 32'(dq_oe), 0);

    // R11 sleep entry and recovery
    begin_read(6'd8, 1'b1); tick();
    quiet(); sleep = 1; cstb_n = 0; gwr_n = 0; addr = 6'd40; wdata = 32'h0;
    tick();
    chk("R11 entry1", 32'(sleep_o), 0);
    chk("R11 ignored strobe", 32'(wr_stb), 0);
    chk("R11 ignored addr", 32'(baddr), 8);
    tick();
    chk("R11 asleep", 32'(sleep_o), 1);
    tick();
    sleep = 0; tick();
    chk("R11 wake", 32'(sleep_o), 0);
    chk("R11 recover1", 32'(wr_stb), 0);
    tick();
    chk("R11 recover2", 32'(wr_stb), 0);
    chk("R11 recover2 addr", 32'(baddr), 8);
    tick();
    chk("R11 accepted", 32'(wr_stb), 32'hF);
    chk("R11 accepted addr", 32'(baddr), 40);

    quiet(); tick();
    finish_run();
  end

endmodule